// File: doc/BRIEF.md
# SEC-DED Codec for a 72/64 Memory Word

This block protects a 64-bit memory word with 8 check bits. The code corrects any single flipped bit and detects any pair of flipped bits. It has two independent paths. The write path takes a data word and returns the 8 check bits to store beside it. The read path takes a stored 72-bit word and recomputes the check bits. It then forms the syndrome and classifies the word as clean, single-error corrected, or uncorrectable. It returns the repaired data, the syndrome, the error position and two status flags. Both paths register their outputs once, and each carries a valid bit alongside its result.

Every column of the parity-check matrix has odd weight, and no two columns are equal. A single error therefore always gives an odd-weight syndrome that equals exactly one column. Two errors always give a nonzero syndrome of even weight. The decoder compares the syndrome against all 72 columns in parallel. A match selects the bit to flip.

Top module: `secded_codec`

## Requirements
- R1: The 72-bit codeword holds data in bits 63..0 and check bits in bits 71..64. The matrix column of data bit j is as follows. For j < 56 it is the j-th 8-bit value of weight 3, counted in ascending numeric order from j = 0. For j >= 56 it is the (j-56)-th such value of weight 5. The column of check bit i is the one-hot value 1<<i. Check bit i of `wr_check_o` is the XOR of the data bits whose column has bit i set.
- R2: `rd_syndrome_o` equals the check bits recomputed from the received data bits, XORed with the received check bits.
- R3: A zero syndrome raises neither flag, reports position 0 and passes the data through unchanged.
- R4: When the syndrome equals the column of data bit j, `rd_corrected_o` is raised, `rd_err_pos_o` is j, and data bit j is inverted in `rd_data_o`.
- R5: When the syndrome equals the column of check bit i, `rd_corrected_o` is raised and `rd_err_pos_o` is 64+i. The data is passed through unchanged.
- R6: Any two flipped bits give a nonzero even-weight syndrome. This raises `rd_uncorrectable_o`, keeps `rd_corrected_o` low, reports position 0 and passes the received data unchanged.
- R7: A nonzero syndrome that matches no column, such as a weight-7 syndrome, is reported as uncorrectable, with the received data passed unchanged.
- R8: Both paths register their results one cycle after their inputs, and each valid output follows its valid input by one cycle. The two paths work independently in the same cycle. Both status flags are low whenever `rd_valid_o` is low.
- R9: While `rst` is high at a clock edge, both valid outputs and both flags are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write data present |
| wr_data_i | input | 64 | Data to encode |
| wr_valid_o | output | 1 | Check bits valid |
| wr_check_o | output | 8 | Generated check bits |
| rd_valid_i | input | 1 | Read codeword present |
| rd_word_i | input | 72 | Received codeword, check bits in 71..64 |
| rd_valid_o | output | 1 | Decode result valid |
| rd_data_o | output | 64 | Corrected data |
| rd_syndrome_o | output | 8 | Syndrome of the received word |
| rd_corrected_o | output | 1 | Single error found and corrected |
| rd_uncorrectable_o | output | 1 | Error that cannot be corrected |
| rd_err_pos_o | output | 7 | Flipped bit position, 0 to 71, valid with the corrected flag |

## Verification
Encoding a write and decoding a read can occur in the same cycle, because the two paths share no state. The bench exploits this by presenting a fresh write word with every read codeword. The read codewords sweep every single-bit error and every two-bit error over several data patterns. Each cycle, the bench compares the check bits of the write against its own matrix arithmetic. In the same comparison it checks the syndrome, flags, position and data of the read, so a leak between the paths shows up as a miscompare. Separate cycles drive only one valid, which confirms that each valid output tracks only its own input.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;

  // Column of data bit j: ascending values of weight 3, then 5, then 7.
  function automatic int unsigned data_col(input int j, input int cw);
    int idx;
    idx = 0;
    for (int w = 3; w <= cw; w += 2) begin
      for (int v = 0; v < (1 << cw); v++) begin
        if ($countones(v) == w) begin
          if (idx == j) return v;
          idx++;
        end
      end
    end
    return 0;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DW = secded_pkg::DATA_W,
  parameter int CW = secded_pkg::CHK_W
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  logic [CW-1:0] term [DW];

  for (genvar j = 0; j < DW; j++) begin : g_col
    localparam logic [CW-1:0] COL = CW'(secded_pkg::data_col(j, CW));
    assign term[j] = data[j] ? COL : '0;
  end

  always_comb begin
    chk = '0;
    for (int j = 0; j < DW; j++) chk = chk ^ term[j];
  end
endmodule

// File: rtl/secded_syn.sv
module secded_syn #(
  parameter int DW = secded_pkg::DATA_W,
  parameter int CW = secded_pkg::CHK_W
) (
  input  logic [DW+CW-1:0] word,
  output logic [CW-1:0]    syn
);
  logic [CW-1:0] recomputed;

  secded_enc #(.DW(DW), .CW(CW)) u_enc (
    .data (word[DW-1:0]),
    .chk  (recomputed)
  );

  assign syn = recomputed ^ word[DW+CW-1:DW];
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DW = secded_pkg::DATA_W,
  parameter int CW = secded_pkg::CHK_W,
  localparam int NW = DW + CW,
  localparam int PW = $clog2(NW)
) (
  input  logic [CW-1:0] syn,
  output logic [DW-1:0] flip,
  output logic          single,
  output logic          uncorr,
  output logic [PW-1:0] pos
);
  logic [NW-1:0] hit;

  for (genvar k = 0; k < NW; k++) begin : g_match
    if (k < DW) begin : g_data
      localparam logic [CW-1:0] COL = CW'(secded_pkg::data_col(k, CW));
      assign hit[k] = (syn == COL);
    end else begin : g_chk
      localparam logic [CW-1:0] COL = CW'(1) << (k - DW);
      assign hit[k] = (syn == COL);
    end
  end

  always_comb begin
    pos = '0;
    for (int k = 0; k < NW; k++) begin
      if (hit[k]) pos = PW'(k);
    end
  end

  assign flip   = hit[DW-1:0];
  assign single = |hit;
  assign uncorr = (syn != '0) && !single;
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DW = secded_pkg::DATA_W,
  parameter int CW = secded_pkg::CHK_W,
  localparam int NW = DW + CW,
  localparam int PW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_valid_o,
  output logic [CW-1:0] wr_check_o,
  input  logic          rd_valid_i,
  input  logic [NW-1:0] rd_word_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] rd_syndrome_o,
  output logic          rd_corrected_o,
  output logic          rd_uncorrectable_o,
  output logic [PW-1:0] rd_err_pos_o
);
  logic [CW-1:0] enc_chk;
  logic [CW-1:0] syn;
  logic [DW-1:0] flip;
  logic          single;
  logic          uncorr;
  logic [PW-1:0] pos;

  secded_enc #(.DW(DW), .CW(CW)) u_enc (
    .data (wr_data_i),
    .chk  (enc_chk)
  );

  secded_syn #(.DW(DW), .CW(CW)) u_syn (
    .word (rd_word_i),
    .syn  (syn)
  );

  secded_dec #(.DW(DW), .CW(CW)) u_dec (
    .syn    (syn),
    .flip   (flip),
    .single (single),
    .uncorr (uncorr),
    .pos    (pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid_o <= 1'b0;
      wr_check_o <= '0;
    end else begin
      wr_valid_o <= wr_valid_i;
      wr_check_o <= enc_chk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o         <= 1'b0;
      rd_data_o          <= '0;
      rd_syndrome_o      <= '0;
      rd_corrected_o     <= 1'b0;
      rd_uncorrectable_o <= 1'b0;
      rd_err_pos_o       <= '0;
    end else begin
      rd_valid_o         <= rd_valid_i;
      rd_data_o          <= rd_word_i[DW-1:0] ^ flip;
      rd_syndrome_o      <= syn;
      rd_corrected_o     <= rd_valid_i && single;
      rd_uncorrectable_o <= rd_valid_i && uncorr;
      rd_err_pos_o       <= pos;
    end
  end
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int DW = secded_pkg::DATA_W,
  parameter int CW = secded_pkg::CHK_W,
  localparam int NW = DW + CW,
  localparam int PW = $clog2(NW)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid_i,
  input logic          wr_valid_o,
  input logic          rd_valid_i,
  input logic [NW-1:0] rd_word_i,
  input logic          rd_valid_o,
  input logic [DW-1:0] rd_data_o,
  input logic [CW-1:0] rd_syndrome_o,
  input logic          rd_corrected_o,
  input logic          rd_uncorrectable_o,
  input logic [PW-1:0] rd_err_pos_o
);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !wr_valid_o && !rd_valid_o && !rd_corrected_o && !rd_uncorrectable_o);

  a_r8_wr_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> wr_valid_o == $past(wr_valid_i));

  a_r8_rd_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_valid_o == $past(rd_valid_i));

  a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> !rd_corrected_o && !rd_uncorrectable_o);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_corrected_o && rd_uncorrectable_o));

  a_r3_zero_syn_clean: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o && rd_syndrome_o == '0 |-> !rd_corrected_o && !rd_uncorrectable_o);

  a_r6_even_syn_uncorr: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o && rd_syndrome_o != '0 && !(^rd_syndrome_o) |-> rd_uncorrectable_o);

  a_r4_corr_odd_syn: assert property (@(posedge clk) disable iff (rst)
    rd_corrected_o |-> ^rd_syndrome_o);

  a_r5_chk_err_data_kept: assert property (@(posedge clk) disable iff (rst)
    rd_corrected_o && (int'(rd_err_pos_o) >= DW) |-> rd_data_o == $past(rd_word_i[DW-1:0]));

  a_r6_uncorr_data_kept: assert property (@(posedge clk) disable iff (rst)
    rd_uncorrectable_o |-> rd_data_o == $past(rd_word_i[DW-1:0]));
endmodule

bind secded_codec secded_codec_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk                (clk),
  .rst                (rst),
  .wr_valid_i         (wr_valid_i),
  .wr_valid_o         (wr_valid_o),
  .rd_valid_i         (rd_valid_i),
  .rd_word_i          (rd_word_i),
  .rd_valid_o         (rd_valid_o),
  .rd_data_o          (rd_data_o),
  .rd_syndrome_o      (rd_syndrome_o),
  .rd_corrected_o     (rd_corrected_o),
  .rd_uncorrectable_o (rd_uncorrectable_o),
  .rd_err_pos_o       (rd_err_pos_o)
);

// File: tb/secded_codec_test.sv
module secded_codec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic        wr_valid_o;
  logic [7:0]  wr_check_o;
  logic        rd_valid_i = 1'b0;
  logic [71:0] rd_word_i = '0;
  logic        rd_valid_o;
  logic [63:0] rd_data_o;
  logic [7:0]  rd_syndrome_o;
  logic        rd_corrected_o;
  logic        rd_uncorrectable_o;
  logic [6:0]  rd_err_pos_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [7:0] cols [64];

  always #5 clk = ~clk;

  secded_codec uut (
    .clk(clk), .rst(rst),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .wr_valid_o(wr_valid_o), .wr_check_o(wr_check_o),
    .rd_valid_i(rd_valid_i), .rd_word_i(rd_word_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_syndrome_o(rd_syndrome_o), .rd_corrected_o(rd_corrected_o),
    .rd_uncorrectable_o(rd_uncorrectable_o), .rd_err_pos_o(rd_err_pos_o)
  );

  function automatic logic [7:0] exp_chk(input logic [63:0] d);
    logic [7:0] c;
    c = '0;
    for (int j = 0; j < 64; j++) if (d[j]) c = c ^ cols[j];
    return c;
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // kind: 0 clean, 1 single error at epos, 2 double, 3 unmatched odd syndrome
  task automatic apply(input logic wv, input logic [63:0] wd,
                       input logic rv, input logic [71:0] rw,
                       input int kind, input int epos, input logic [63:0] edata,
                       input string tag);
    wr_valid_i = wv; wr_data_i = wd;
    rd_valid_i = rv; rd_word_i = rw;
    @(negedge clk);
    vectors++;
    cmp("R8", "wr_valid", 72'(wr_valid_o), 72'(wv));
    if (wv) cmp("R1", "check", 72'(wr_check_o), 72'(exp_chk(wd)));
    cmp("R8", "rd_valid", 72'(rd_valid_o), 72'(rv));
    if (rv) begin
      cmp("R2", "syndrome", 72'(rd_syndrome_o), 72'(exp_chk(rw[63:0]) ^ rw[71:64]));
      cmp(tag, "corrected", 72'(rd_corrected_o), 72'(kind == 1));
      cmp(tag, "uncorrectable", 72'(rd_uncorrectable_o), 72'(kind >= 2));
      if (kind != 1) cmp(tag, "pos", 72'(rd_err_pos_o), 72'(0));
      else cmp(tag, "pos", 72'(rd_err_pos_o), 72'(epos));
      cmp(tag, "data", 72'(rd_data_o), 72'(edata));
    end else begin
      cmp("R8", "corrected idle", 72'(rd_corrected_o), 72'(0));
      cmp("R8", "uncorrectable idle", 72'(rd_uncorrectable_o), 72'(0));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [5];
    logic [63:0] d;
    logic [71:0] cw;
    logic [71:0] bad;
    logic [63:0] wd;
    int idx;

    // Column table derived from R1: weight-3 values ascending, then weight-5.
    idx = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < 256; v++)
        if ($countones(v) == w && idx < 64) begin
          cols[idx] = 8'(v);
          idx++;
        end

    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'hA5A5_5A5A_C3C3_3C3C;
    pats[4] = 64'h0000_0020_0000_0000;

    // R9: reset with both valids held high
    wr_valid_i = 1'b1; rd_valid_i = 1'b1; rd_word_i = 72'h1;
    repeat (3) @(negedge clk);
    vectors++;
    cmp("R9", "wr_valid reset", 72'(wr_valid_o), 72'(0));
    cmp("R9", "rd_valid reset", 72'(rd_valid_o), 72'(0));
    cmp("R9", "corrected reset", 72'(rd_corrected_o), 72'(0));
    cmp("R9", "uncorrectable reset", 72'(rd_uncorrectable_o), 72'(0));
    rst = 1'b0;

    // R8: each path alone
    apply(1'b1, pats[2], 1'b0, '0, 0, 0, '0, "R8");
    apply(1'b0, '0, 1'b1, {exp_chk(pats[3]), pats[3]}, 0, 0, pats[3], "R3");

    for (int p = 0; p < 5; p++) begin
      d = pats[p];
      cw = {exp_chk(d), d};
      wd = {d[31:0], d[63:32]} ^ 64'(p * 64'h9E37_79B9);
      apply(1'b1, wd, 1'b1, cw, 0, 0, d, "R3");
      // every single-bit error
      for (int b = 0; b < 72; b++) begin
        bad = cw ^ (72'h1 << b);
        wd = wd ^ (64'h1 << (b % 64));
        apply(1'b1, wd, 1'b1, bad, 1, b, d, (b < 64) ? "R4" : "R5");
      end
    end

    // every double-bit error on three patterns
    for (int p = 1; p < 4; p++) begin
      d = pats[p];
      cw = {exp_chk(d), d};
      for (int a = 0; a < 72; a++)
        for (int b = a + 1; b < 72; b++) begin
          bad = cw ^ (72'h1 << a) ^ (72'h1 << b);
          wd = bad[63:0] ^ {bad[7:0], bad[71:16]};
          apply(1'b1, wd, (b % 7) != 3, bad, 2, 0, bad[63:0], "R6");
        end
    end

    // R7: weight-7 syndrome matches no column
    apply(1'b1, 64'h1, 1'b1, {8'h7F, 64'h0}, 3, 0, 64'h0, "R7");
    apply(1'b0, '0, 1'b1, {8'hFE ^ exp_chk(pats[2]), pats[2]}, 3, 0, pats[2], "R7");

    // idle cycle
    apply(1'b0, '0, 1'b0, '0, 0, 0, '0, "R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule